// File: doc/BRIEF.md
# Digital Bandpass Delta-Sigma Loop

This block is a bit-exact, fixed-point model of a second-order bandpass delta-sigma loop. Two resonators are chained. Each has the response z^-1/(1 + a·z^-1 + z^-2). A 32-level quantizer closes the loop. The resulting noise transfer function is (1 + ai·z^-1 + z^-2)(1 + aj·z^-1 + z^-2), which puts two conjugate zero pairs on the unit circle. With the default coefficients the zero pairs sit close to half the sample rate. Two first-order feedback branches return the quantized level into the resonator inputs. Their taps are derived so that the signal path is a pure delay of two samples.

A sample is accepted on each clock edge where `smp_en` is high. For that sample the block delivers two results. The first is a 5-bit quantizer code. The second is the quantization error, which is the quantizer input minus the reconstructed level. A following cascade stage takes this error as its input. The two coefficients are parameters in units of 1/8. The feedback taps are computed from them at elaboration in units of 1/64. The resonator states saturate instead of wrapping, and a sticky flag records that saturation has occurred.

Top module: `bpdsm_loop`

## Requirements
- R1: A synchronous reset zeroes every resonator state and the stored previous level. After reset, `code_out` = 16 (level 0), `qerr_out` = 0, `out_valid` = 0 and `sat_flag` = 0.
- R2: On a clock edge with `smp_en` low, no state changes. `code_out`, `qerr_out` and `sat_flag` hold their values and `out_valid` is 0.
- R3: `out_valid` is 1 in the cycle after each accepted sample and 0 otherwise. `code_out` and `qerr_out` then reflect the quantization of the second resonator's state as it stood when that sample was accepted.
- R4: The quantizer level is floor(y + 1/2), clamped to [-16, 15]. Here y is the second resonator state and the level step is 1.0. `code_out` is level + 16 as a 5-bit unsigned value, so code 0 means -16 and code 31 means +15.
- R5: `qerr_out` = y − level·2^FRAC_W, for the same sample, in signed fixed point with FRAC_W fractional bits. When the level is not clamped, the error lies in [−1/2, 1/2).
- R6: Each resonator updates as s[n+1] = u[n] − ((a64·s[n]) >>> 6) − s[n−1]. The value a64 is the coefficient in 1/64 units and the shift is arithmetic, rounding toward minus infinity. The first resonator uses aj and the second uses ai.
- R7: With v the current level and v' the previous level, the first resonator input is x + (1 − aj²)·v − aj·v'. The second resonator input is s1 + (ai + aj)·v + 1·v'.
- R8: An isolated input impulse of integer amplitude k (|k| ≤ 8), applied after reset and zero input, produces level 0 for the sample it is applied on and for the next sample. The sample after that carries level k with zero error.
- R9: A resonator result beyond the STATE_W signed range is clipped to that range. The clip raises `sat_flag`, which then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Accept `smp_in` on this edge and advance the loop |
| smp_in | input | X_W | Signed input sample, FRAC_W fractional bits |
| code_out | output | Q_BITS | Quantizer code, level + 16 |
| qerr_out | output | STATE_W+1 | Signed quantization error, FRAC_W fractional bits |
| out_valid | output | 1 | A new code and error were produced on the last edge |
| sat_flag | output | 1 | Sticky: a resonator state was clipped since reset |

## Verification
The embedded properties watch several rules on every cycle: the reset values, the state freeze while enable is low, the valid timing, the sticky saturation flag, the one-step shift of each resonator's history, and the half-step error bound whenever the quantizer is not clamped. The bench's scenarios are the only place where the arithmetic itself shows up. These cover the resonator recursion with its truncation, the feedback taps derived from the coefficients, the two-sample signal delay seen in an impulse, the clamping of the quantizer under overload, and the clipping that follows it. A behavioural model predicts every output on every cycle for those scenarios.

// File: rtl/bpdsm_pkg.sv
`timescale 1ns/1ps
package bpdsm_pkg;

    // Coefficients are held in units of 1/2^COEF_FRAC.
    localparam int COEF_FRAC  = 6;
    localparam int COEF_ONE   = 1 << COEF_FRAC;
    localparam int NUM_STAGES = 2;

    // Loop position of a resonator: the outer one sees the input sample.
    typedef enum logic [0:0] {
        STAGE_OUTER = 1'b0,
        STAGE_INNER = 1'b1
    } stage_e;

    function automatic stage_e stage_kind(int idx);
        return (idx == 0) ? STAGE_OUTER : STAGE_INNER;
    endfunction

    // Resonator coefficient (1/8 units in, 1/64 units out).
    function automatic int res_a64(stage_e st, int ai8, int aj8);
        return ((st == STAGE_OUTER) ? aj8 : ai8) * (COEF_ONE / 8);
    endfunction

    // Present-level tap of the feedback branch that enters a stage.
    function automatic int fb_b64(stage_e st, int ai8, int aj8);
        if (st == STAGE_OUTER)
            return COEF_ONE - aj8 * aj8;          // 1 - aj^2
        else
            return (ai8 + aj8) * (COEF_ONE / 8);  // ai + aj
    endfunction

    // Previous-level tap of the feedback branch that enters a stage.
    function automatic int fb_c64(stage_e st, int aj8);
        if (st == STAGE_OUTER)
            return -aj8 * (COEF_ONE / 8);         // -aj
        else
            return COEF_ONE;                      // 1
    endfunction

endpackage

// File: rtl/bpdsm_feedback.sv
`timescale 1ns/1ps
module bpdsm_feedback #(
    parameter int LVL_W  = 5,
    parameter int WIDE_W = 38,
    parameter int FRAC_W = 10,
    parameter int B64    = 0,
    parameter int C64    = 0
) (
    input  logic signed [LVL_W-1:0]  lvl_now_i,
    input  logic signed [LVL_W-1:0]  lvl_prev_i,
    output logic signed [WIDE_W-1:0] fb_o
);
    import bpdsm_pkg::*;

    localparam int SCALE_SH = FRAC_W - COEF_FRAC;
    localparam logic signed [WIDE_W-1:0] B_W = WIDE_W'(B64);
    localparam logic signed [WIDE_W-1:0] C_W = WIDE_W'(C64);

    logic signed [WIDE_W-1:0] now_w;
    logic signed [WIDE_W-1:0] prev_w;

    always_comb begin
        now_w  = {{(WIDE_W-LVL_W){lvl_now_i[LVL_W-1]}},  lvl_now_i};
        prev_w = {{(WIDE_W-LVL_W){lvl_prev_i[LVL_W-1]}}, lvl_prev_i};
        // level is an integer; taps are in 1/64; result lands in FRAC_W format
        fb_o   = (now_w * B_W + prev_w * C_W) <<< SCALE_SH;
    end

endmodule

// File: rtl/bpdsm_resonator.sv
`timescale 1ns/1ps
module bpdsm_resonator #(
    parameter int STATE_W = 24,
    parameter int WIDE_W  = 38,
    parameter int A64     = 96
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [WIDE_W-1:0]  drive_i,
    output logic signed [STATE_W-1:0] y_o,
    output logic                      sat_o
);
    import bpdsm_pkg::*;

    localparam logic signed [WIDE_W-1:0] A_W   = WIDE_W'(A64);
    localparam logic signed [WIDE_W-1:0] Y_MAX = (WIDE_W'(1) <<< (STATE_W-1)) - WIDE_W'(1);
    localparam logic signed [WIDE_W-1:0] Y_MIN = -Y_MAX - WIDE_W'(1);

    logic signed [STATE_W-1:0] y_q;
    logic signed [STATE_W-1:0] y_prev_q;
    logic signed [STATE_W-1:0] y_next;
    logic signed [WIDE_W-1:0]  y_w;
    logic signed [WIDE_W-1:0]  yp_w;
    logic signed [WIDE_W-1:0]  prod;
    logic signed [WIDE_W-1:0]  sum;

    // s[n+1] = u[n] - a*s[n] - s[n-1], product truncated toward -inf
    always_comb begin
        y_w   = {{(WIDE_W-STATE_W){y_q[STATE_W-1]}},      y_q};
        yp_w  = {{(WIDE_W-STATE_W){y_prev_q[STATE_W-1]}}, y_prev_q};
        prod  = (y_w * A_W) >>> COEF_FRAC;
        sum   = drive_i - prod - yp_w;
        sat_o = 1'b0;
        if (sum > Y_MAX) begin
            y_next = Y_MAX[STATE_W-1:0];
            sat_o  = 1'b1;
        end else if (sum < Y_MIN) begin
            y_next = Y_MIN[STATE_W-1:0];
            sat_o  = 1'b1;
        end else begin
            y_next = sum[STATE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q      <= '0;
            y_prev_q <= '0;
        end else if (en) begin
            y_prev_q <= y_q;
            y_q      <= y_next;
        end
    end

    assign y_o = y_q;

    p_state_clear_r1: assert property (@(posedge clk)
        rst |=> (y_q == '0 && y_prev_q == '0));

    p_state_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(y_q) && $stable(y_prev_q)));

    p_history_shift_r6: assert property (@(posedge clk) disable iff (rst)
        en |=> (y_prev_q == $past(y_q)));

    p_clip_rail_r9: assert property (@(posedge clk) disable iff (rst)
        (en && sat_o) |=> (y_q == Y_MAX[STATE_W-1:0] || y_q == Y_MIN[STATE_W-1:0]));

endmodule

// File: rtl/bpdsm_quantizer.sv
`timescale 1ns/1ps
module bpdsm_quantizer #(
    parameter int STATE_W = 24,
    parameter int FRAC_W  = 10,
    parameter int Q_BITS  = 5
) (
    input  logic signed [STATE_W-1:0] y_i,
    output logic signed [Q_BITS-1:0]  lvl_o,
    output logic signed [STATE_W:0]   err_o
);
    localparam int EXT_W = STATE_W + 1;
    localparam logic signed [EXT_W-1:0] HALF_E = EXT_W'(1) <<< (FRAC_W-1);
    localparam logic signed [EXT_W-1:0] LMAX_E = EXT_W'((1 << (Q_BITS-1)) - 1);
    localparam logic signed [EXT_W-1:0] LMIN_E = -LMAX_E - EXT_W'(1);

    logic signed [EXT_W-1:0] y_e;
    logic signed [EXT_W-1:0] rnd;
    logic signed [EXT_W-1:0] lvl_e;

    always_comb begin
        y_e = {y_i[STATE_W-1], y_i};
        rnd = (y_e + HALF_E) >>> FRAC_W;    // floor(y + 1/2)
        if (rnd > LMAX_E)
            lvl_e = LMAX_E;
        else if (rnd < LMIN_E)
            lvl_e = LMIN_E;
        else
            lvl_e = rnd;
        lvl_o = lvl_e[Q_BITS-1:0];
        err_o = y_e - (lvl_e <<< FRAC_W);
    end

endmodule

// File: rtl/bpdsm_loop.sv
`timescale 1ns/1ps
module bpdsm_loop #(
    parameter int X_W     = 16,
    parameter int STATE_W = 24,
    parameter int FRAC_W  = 10,
    parameter int Q_BITS  = 5,
    parameter int AI8     = 12,
    parameter int AJ8     = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_en,
    input  logic signed [X_W-1:0]    smp_in,
    output logic [Q_BITS-1:0]        code_out,
    output logic signed [STATE_W:0]  qerr_out,
    output logic                     out_valid,
    output logic                     sat_flag
);
    import bpdsm_pkg::*;

    localparam int ERR_W  = STATE_W + 1;
    localparam int WIDE_W = STATE_W + 14;
    localparam logic [Q_BITS-1:0] CODE_MID = {1'b1, {(Q_BITS-1){1'b0}}};
    localparam logic [Q_BITS-1:0] CODE_TOP = '1;
    localparam logic signed [ERR_W-1:0] HALF_E = ERR_W'(1) <<< (FRAC_W-1);

    logic signed [WIDE_W-1:0]  src_w   [NUM_STAGES];
    logic signed [WIDE_W-1:0]  fb_w    [NUM_STAGES];
    logic signed [WIDE_W-1:0]  drive_w [NUM_STAGES];
    logic signed [STATE_W-1:0] y_w     [NUM_STAGES];
    logic [NUM_STAGES-1:0]     sat_v;

    logic signed [Q_BITS-1:0]  lvl_n;
    logic signed [ERR_W-1:0]   err_n;
    logic signed [Q_BITS-1:0]  lvl_q;     // also serves as v[n-1]
    logic signed [ERR_W-1:0]   err_q;
    logic                      valid_q;
    logic                      sat_q;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        localparam stage_e ST = stage_kind(k);

        if (k == 0) begin : g_src_in
            assign src_w[k] = {{(WIDE_W-X_W){smp_in[X_W-1]}}, smp_in};
        end else begin : g_src_chain
            assign src_w[k] = {{(WIDE_W-STATE_W){y_w[k-1][STATE_W-1]}}, y_w[k-1]};
        end

        bpdsm_feedback #(
            .LVL_W  (Q_BITS),
            .WIDE_W (WIDE_W),
            .FRAC_W (FRAC_W),
            .B64    (fb_b64(ST, AI8, AJ8)),
            .C64    (fb_c64(ST, AJ8))
        ) u_fb (
            .lvl_now_i  (lvl_n),
            .lvl_prev_i (lvl_q),
            .fb_o       (fb_w[k])
        );

        assign drive_w[k] = src_w[k] + fb_w[k];

        bpdsm_resonator #(
            .STATE_W (STATE_W),
            .WIDE_W  (WIDE_W),
            .A64     (res_a64(ST, AI8, AJ8))
        ) u_res (
            .clk     (clk),
            .rst     (rst),
            .en      (smp_en),
            .drive_i (drive_w[k]),
            .y_o     (y_w[k]),
            .sat_o   (sat_v[k])
        );
    end

    bpdsm_quantizer #(
        .STATE_W (STATE_W),
        .FRAC_W  (FRAC_W),
        .Q_BITS  (Q_BITS)
    ) u_quant (
        .y_i   (y_w[NUM_STAGES-1]),
        .lvl_o (lvl_n),
        .err_o (err_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            err_q   <= '0;
            valid_q <= 1'b0;
            sat_q   <= 1'b0;
        end else begin
            valid_q <= smp_en;
            if (smp_en) begin
                lvl_q <= lvl_n;
                err_q <= err_n;
                sat_q <= sat_q | (|sat_v);
            end
        end
    end

    // offset binary: flip the sign bit of the two's-complement level
    assign code_out  = {~lvl_q[Q_BITS-1], lvl_q[Q_BITS-2:0]};
    assign qerr_out  = err_q;
    assign out_valid = valid_q;
    assign sat_flag  = sat_q;

    p_reset_outputs_r1: assert property (@(posedge clk)
        rst |=> (code_out == CODE_MID && qerr_out == '0 && !out_valid && !sat_flag));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(code_out) && $stable(qerr_out) && $stable(sat_flag) && !out_valid));

    p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> out_valid);

    p_err_half_step_r5: assert property (@(posedge clk) disable iff (rst)
        (code_out != '0 && code_out != CODE_TOP) |-> (qerr_out >= -HALF_E && qerr_out < HALF_E));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sat_flag |=> sat_flag);

endmodule

// File: tb/test_bpdsm_loop.sv
`timescale 1ns/1ps
module test_bpdsm_loop;
    localparam int X_W     = 16;
    localparam int STATE_W = 18;
    localparam int FRAC_W  = 10;
    localparam int Q_BITS  = 5;
    localparam int AI8     = 12;
    localparam int AJ8     = 15;
    localparam int ERR_W   = STATE_W + 1;

    // Taps from the requirements (1/64 units)
    localparam longint AI64 = AI8 * 8;
    localparam longint AJ64 = AJ8 * 8;
    localparam longint B1   = 64 - AJ8 * AJ8;   // 1 - aj^2
    localparam longint C1   = -AJ8 * 8;         // -aj
    localparam longint B2   = (AI8 + AJ8) * 8;  // ai + aj
    localparam longint C2   = 64;
    localparam longint SMAX = (64'sd1 <<< (STATE_W - 1)) - 1;
    localparam longint SMIN = -SMAX - 1;
    localparam longint ONE  = 64'sd1 <<< FRAC_W;

    logic clk = 1'b0;
    logic rst;
    logic smp_en;
    logic signed [X_W-1:0]   smp_in;
    logic [Q_BITS-1:0]       code_out;
    logic signed [ERR_W-1:0] qerr_out;
    logic out_valid;
    logic sat_flag;

    always #4 clk = ~clk;

    bpdsm_loop #(
        .X_W(X_W), .STATE_W(STATE_W), .FRAC_W(FRAC_W),
        .Q_BITS(Q_BITS), .AI8(AI8), .AJ8(AJ8)
    ) i_bpdsm_loop (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in),
        .code_out(code_out), .qerr_out(qerr_out),
        .out_valid(out_valid), .sat_flag(sat_flag)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural model state
    longint m_s1 = 0, m_s1p = 0, m_s2 = 0, m_s2p = 0, m_vp = 0, m_err = 0;
    longint m_lvl = 0;
    bit m_valid = 1'b0, m_sat = 1'b0;

    function automatic longint clip(longint v, ref bit hit);
        if (v > SMAX) begin hit = 1'b1; return SMAX; end
        if (v < SMIN) begin hit = 1'b1; return SMIN; end
        return v;
    endfunction

    task automatic model_step(input bit r, input bit e, input longint x);
        longint lvl, n1, n2;
        bit hit;
        if (r) begin
            m_s1 = 0; m_s1p = 0; m_s2 = 0; m_s2p = 0; m_vp = 0;
            m_lvl = 0; m_err = 0; m_valid = 1'b0; m_sat = 1'b0;
        end else if (!e) begin
            m_valid = 1'b0;
        end else begin
            hit = 1'b0;
            lvl = (m_s2 + ONE / 2) >>> FRAC_W;
            if (lvl > 15)  lvl = 15;
            if (lvl < -16) lvl = -16;
            m_err = m_s2 - lvl * ONE;
            n1 = x + (B1 * lvl + C1 * m_vp) * (ONE / 64)
                 - ((AJ64 * m_s1) >>> 6) - m_s1p;
            n2 = m_s1 + (B2 * lvl + C2 * m_vp) * (ONE / 64)
                 - ((AI64 * m_s2) >>> 6) - m_s2p;
            n1 = clip(n1, hit);
            n2 = clip(n2, hit);
            m_s1p = m_s1; m_s1 = n1;
            m_s2p = m_s2; m_s2 = n2;
            m_vp  = lvl;
            m_lvl = lvl;
            m_valid = 1'b1;
            m_sat = m_sat | hit;
        end
    endtask

    task automatic compare(input string tag);
        longint exp_code;
        exp_code = m_lvl + 16;
        checks++;
        if (longint'(code_out) != exp_code || longint'(qerr_out) != m_err ||
            out_valid !== m_valid || sat_flag !== m_sat) begin
            errors++;
            $display("FAIL %s: code=%0d err=%0d valid=%0b sat=%0b expected code=%0d err=%0d valid=%0b sat=%0b",
                     tag, code_out, qerr_out, out_valid, sat_flag,
                     exp_code, m_err, m_valid, m_sat);
        end
    endtask

    task automatic check_val(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // inputs change at the falling edge; outputs are compared at the next one
    task automatic step(input bit r, input bit e, input longint x, input string tag);
        rst    = r;
        smp_en = e;
        smp_in = X_W'(x);
        @(posedge clk);
        model_step(r, e, x);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint hold_code, hold_err, x;
        bit saw_clamp;
        rst = 1'b1; smp_en = 1'b0; smp_in = '0;
        @(negedge clk);

        // R1: reset values
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, "R1 reset");
        check_val("R1 code after reset", longint'(code_out), 16);
        check_val("R1 err after reset", longint'(qerr_out), 0);
        check_val("R1 valid after reset", longint'(out_valid), 0);
        check_val("R1 flag after reset", longint'(sat_flag), 0);

        // R7: zero input keeps the loop at level 0
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 0, "R7 zero input");
        check_val("R7 zero input level", longint'(code_out), 16);
        check_val("R3 valid after accepted sample", longint'(out_valid), 1);

        // R8: impulse of amplitude 3 appears two samples later
        step(1'b0, 1'b1, 3 * ONE, "R8 impulse");
        check_val("R8 impulse sample n", longint'(code_out), 16);
        step(1'b0, 1'b1, 0, "R8 impulse");
        check_val("R8 impulse sample n+1", longint'(code_out), 16);
        step(1'b0, 1'b1, 0, "R8 impulse");
        check_val("R8 impulse sample n+2", longint'(code_out), 19);
        check_val("R8 impulse error", longint'(qerr_out), 0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 0, "R6 ringing");

        // R4 R5 R6 R7: tone near the zero band
        for (int i = 0; i < 300; i++) begin
            x = longint'($rtoi(3.0 * ONE * $cos(2.0 * 3.14159265 * 0.445 * i)));
            step(1'b0, 1'b1, x, "R6 tone");
        end

        // R2: gated enable
        for (int i = 0; i < 150; i++) begin
            x = longint'($rtoi(2.5 * ONE * $cos(2.0 * 3.14159265 * 0.43 * i)));
            hold_code = longint'(code_out);
            hold_err  = longint'(qerr_out);
            step(1'b0, (i % 3) != 0, x, "R2 gated");
            if ((i % 3) == 0) begin
                check_val("R2 code held", longint'(code_out), hold_code);
                check_val("R2 err held", longint'(qerr_out), hold_err);
                check_val("R3 valid low when idle", longint'(out_valid), 0);
            end
        end

        // R1: reset in mid-run
        step(1'b1, 1'b1, ONE, "R1 mid reset");
        check_val("R1 mid-run code", longint'(code_out), 16);
        check_val("R1 mid-run err", longint'(qerr_out), 0);

        // R9 R4: overload drives clamp and clipping
        saw_clamp = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step(1'b0, 1'b1, (i % 2 == 0) ? 32767 : -32767, "R9 overload");
            if (code_out == 0 || code_out == 31) saw_clamp = 1'b1;
        end
        check_val("R4 quantizer clamp reached", longint'(saw_clamp), 1);
        check_val("R9 flag raised", longint'(sat_flag), 1);
        for (int i = 0; i < 30; i++) step(1'b0, (i % 4) != 0, 0, "R9 after overload");
        check_val("R9 flag sticky", longint'(sat_flag), 1);
        step(1'b1, 1'b0, 0, "R1 final reset");
        check_val("R9 flag cleared by reset", longint'(sat_flag), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule